// File: doc/BRIEF.md
# Strided Vector Load Engine

This block carries out one vector load at a time. A start command supplies a base word address, a stride, an element count and a destination vector register. The engine steps through the element addresses `base + i*stride` in order and presents them one per cycle at most on a single request port. That port feeds a memory made of interleaved single-ported banks. Each data word that comes back is written into the destination register at the element index matching its position in the sequence.

Each bank stays occupied for a fixed number of cycles after it is accessed. The engine keeps a countdown per bank and holds issue whenever the next element falls on a bank that is still occupied. As a result, strides that keep returning to a few banks run slower than strides that spread across all of them. Every returned word is checked against its stored check byte. Data is never corrected. A double-bit fault raises a flag that stays set until the next load starts, and the load still runs to its end.

Top module: `svl_load_unit`

## Requirements
- R1: After reset, busy_o, done_o, ecc_err_o, mem_req_valid_o and vrf_we_o are all 0.
- R2: Element i is requested at word address base + i*stride, taken modulo 2^32. Elements are requested strictly in increasing i, with at most one request per cycle. mem_req_bank_o equals address bits [3:0].
- R3: A bank that takes a request at cycle t receives no other request before cycle t+4, and this holds across back-to-back loads. Subject to that rule, every element issues at the earliest cycle allowed. Element 0 may issue in the first cycle after the start is captured, and each later element may issue one cycle after its predecessor.
- R4: The k-th response to arrive is written one cycle after it arrives. The write uses vrf_reg_o equal to the destination register, vrf_idx_o equal to k, and vrf_data_o equal to the response data, unchanged.
- R5: An element count above 64 is treated as 64. Exactly 64 requests and 64 writes result, to indices 0 through 63.
- R6: An element count of 0 pulses done_o in the first cycle after the start is captured. It produces no request and no write, and busy_o stays 0.
- R7: busy_o is 1 from the cycle after the start is captured until the final write. done_o is a one-cycle pulse in the same cycle as the final write, and in that cycle busy_o is already 0.
- R8: A start presented while busy_o is 1 is ignored. The running load's addresses, destination register, indices and count are unaffected.
- R9: The check byte works as follows. Data bit i has column code c_i, the i-th integer ≥ 3 (counting from 0) that is not a power of two. Check bit j (j<7) is the XOR of the data bits whose c_i has bit j set. Check bit 7 makes the parity of all 72 bits even. A response whose recomputed syndrome is nonzero while the overall parity is even sets ecc_err_o. The flag holds until the next accepted start clears it. A single-bit fault (odd parity) does not set the flag. In both cases the load completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid_i | input | 1 | Start a load (accepted only when idle) |
| start_base_i | input | 32 | Base word address |
| start_stride_i | input | 32 | Stride in words (two's complement) |
| start_len_i | input | 7 | Element count, clamped to 64 |
| start_vreg_i | input | 4 | Destination vector register |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ecc_err_o | output | 1 | Sticky uncorrectable-fault flag for the current load |
| mem_req_valid_o | output | 1 | Element request issued this cycle |
| mem_req_addr_o | output | 32 | Element word address |
| mem_req_bank_o | output | 4 | Target bank |
| mem_rsp_valid_i | input | 1 | Response word present (in issue order) |
| mem_rsp_data_i | input | 64 | Response data |
| mem_rsp_check_i | input | 8 | Response check byte |
| vrf_we_o | output | 1 | Vector register write enable |
| vrf_reg_o | output | 4 | Vector register written |
| vrf_idx_o | output | 6 | Element index written |
| vrf_data_o | output | 64 | Element data written |

## Verification
Every stride from 0 to 33 is swept, together with strides that wrap around the address space and negative ones. Strides with no common factor with 16 show that issue runs at one element per cycle. Strides of 8 and 16 and their multiples pile onto two banks or one, and the exact stall cycles this produces are compared against an arithmetic bank-occupancy model. A length sweep from 0 to 66 and lengths of 100 and 127 exercise the empty load and the clamp at 64. Single-bit and double-bit faults at a chosen element separate "flagged" from "not flagged" while the data still arrives unaltered. A start presented mid-load shows that it leaves the running load unchanged.

// File: rtl/svl_pkg.sv
package svl_pkg;

  typedef enum logic {
    SVL_IDLE = 1'b0,
    SVL_RUN  = 1'b1
  } svl_state_e;

  // Column code of data bit idx: the idx-th integer >= 3 that is not a power of two.
  function automatic int svl_col_code(input int idx, input int syn_w);
    int n;
    int r;
    n = 0;
    r = 0;
    for (int c = 3; c < (1 << syn_w); c++) begin
      if ((c & (c - 1)) != 0) begin
        if (n == idx) r = c;
        n++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/svl_addr_gen.sv
module svl_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              advance_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              more_o
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] stride_q, stride_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic              en;

  always_comb begin
    addr_d   = addr_q;
    stride_d = stride_q;
    cnt_d    = cnt_q;
    en       = 1'b0;
    if (load_i) begin
      addr_d   = base_i;
      stride_d = stride_i;
      cnt_d    = '0;
      en       = 1'b1;
    end else if (advance_i) begin
      addr_d = addr_q + stride_q;
      cnt_d  = cnt_q + LEN_W'(1);
      en     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      stride_q <= '0;
      cnt_q    <= '0;
    end else if (en) begin
      addr_q   <= addr_d;
      stride_q <= stride_d;
      cnt_q    <= cnt_d;
    end
  end

  assign addr_o = addr_q;
  assign more_o = (cnt_q < len_i);

  // R2: each issued element advances the address by exactly one stride
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !load_i) |=> (addr_q == $past(addr_q + stride_q)));

  // R2: no element is issued beyond the element count
  p_no_extra_r2: assert property (@(posedge clk) disable iff (!rst_n)
    advance_i |-> (cnt_q < len_i));

endmodule

// File: rtl/svl_bank_timers.sv
module svl_bank_timers #(
  parameter int NUM_BANKS = 16,
  parameter int BANK_BUSY = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int TMR_W    = $clog2(BANK_BUSY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              free_o
);

  logic [NUM_BANKS-1:0] busy_vec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [TMR_W-1:0] tmr_q, tmr_d;
    logic             hit;

    assign hit = issue_i && (bank_i == BANK_W'(b));

    always_comb begin
      tmr_d = tmr_q;
      if (hit)               tmr_d = TMR_W'(BANK_BUSY - 1);
      else if (tmr_q != '0)  tmr_d = tmr_q - TMR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   tmr_q <= '0;
      else if (hit || tmr_q != '0)  tmr_q <= tmr_d;
    end

    assign busy_vec[b] = (tmr_q != '0);
  end

  assign free_o = ~busy_vec[bank_i];

  // R3: a request never lands on a bank that is still occupied
  p_bank_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> !busy_vec[bank_i]);

  // R3: an accessed bank is occupied in the following cycle
  p_bank_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> busy_vec[$past(bank_i)]);

endmodule

// File: rtl/svl_ecc_check.sv
module svl_ecc_check #(
  parameter int DATA_W = 64,
  localparam int SYN_W = $clog2(DATA_W) + 1,
  localparam int CHK_W = SYN_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic              uncorrectable_o
);

  function automatic logic [DATA_W-1:0] cover_mask(input int j);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      m[i] = ((svl_pkg::svl_col_code(i, SYN_W) >> j) & 1) != 0;
    end
    return m;
  endfunction

  logic [SYN_W-1:0] syn;
  logic             par_odd;

  for (genvar j = 0; j < SYN_W; j++) begin : g_syn
    localparam logic [DATA_W-1:0] MASK = cover_mask(j);
    assign syn[j] = (^(data_i & MASK)) ^ chk_i[j];
  end

  assign par_odd         = ^{data_i, chk_i};
  assign uncorrectable_o = (|syn) & ~par_odd;

endmodule

// File: rtl/svl_load_unit.sv
module svl_load_unit #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int NUM_BANKS = 16,
  parameter int BANK_BUSY = 4,
  parameter int MAX_VL    = 64,
  parameter int NUM_VREGS = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int LEN_W    = $clog2(MAX_VL + 1),
  localparam int IDX_W    = $clog2(MAX_VL),
  localparam int VREG_W   = $clog2(NUM_VREGS),
  localparam int CHK_W    = $clog2(DATA_W) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid_i,
  input  logic [ADDR_W-1:0] start_base_i,
  input  logic [ADDR_W-1:0] start_stride_i,
  input  logic [LEN_W-1:0]  start_len_i,
  input  logic [VREG_W-1:0] start_vreg_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ecc_err_o,
  output logic              mem_req_valid_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [BANK_W-1:0] mem_req_bank_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i,
  input  logic [CHK_W-1:0]  mem_rsp_check_i,
  output logic              vrf_we_o,
  output logic [VREG_W-1:0] vrf_reg_o,
  output logic [IDX_W-1:0]  vrf_idx_o,
  output logic [DATA_W-1:0] vrf_data_o
);

  import svl_pkg::*;

  svl_state_e        state_q, state_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [VREG_W-1:0] vreg_q, vreg_d;
  logic [LEN_W-1:0]  rsp_cnt_q, rsp_cnt_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              we_q, we_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  logic              start_acc;
  logic [LEN_W-1:0]  len_clamp;
  logic              running;
  logic              more;
  logic              bank_free;
  logic              issue;
  logic [ADDR_W-1:0] cur_addr;
  logic              rsp_take;
  logic              rsp_last;
  logic              rsp_bad;
  logic              ctl_en;

  assign start_acc = start_valid_i && (state_q == SVL_IDLE);
  assign running   = (state_q == SVL_RUN);
  assign len_clamp = (int'(start_len_i) > MAX_VL) ? LEN_W'(MAX_VL) : start_len_i;

  svl_addr_gen #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) i_addr_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (start_acc),
    .base_i    (start_base_i),
    .stride_i  (start_stride_i),
    .advance_i (issue),
    .len_i     (len_q),
    .addr_o    (cur_addr),
    .more_o    (more)
  );

  svl_bank_timers #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_BUSY (BANK_BUSY)
  ) i_bank_timers (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue_i (issue),
    .bank_i  (cur_addr[BANK_W-1:0]),
    .free_o  (bank_free)
  );

  svl_ecc_check #(
    .DATA_W (DATA_W)
  ) i_ecc_check (
    .data_i          (mem_rsp_data_i),
    .chk_i           (mem_rsp_check_i),
    .uncorrectable_o (rsp_bad)
  );

  assign issue    = running && more && bank_free;
  assign rsp_take = running && mem_rsp_valid_i;
  assign rsp_last = (rsp_cnt_q == len_q - LEN_W'(1));

  always_comb begin
    state_d   = state_q;
    len_d     = len_q;
    vreg_d    = vreg_q;
    rsp_cnt_d = rsp_cnt_q;
    err_d     = err_q;
    done_d    = 1'b0;
    we_d      = 1'b0;
    idx_d     = idx_q;
    wdata_d   = wdata_q;
    if (start_acc) begin
      len_d     = len_clamp;
      vreg_d    = start_vreg_i;
      rsp_cnt_d = '0;
      err_d     = 1'b0;
      if (len_clamp == '0) done_d  = 1'b1;
      else                 state_d = SVL_RUN;
    end
    if (rsp_take) begin
      we_d      = 1'b1;
      idx_d     = rsp_cnt_q[IDX_W-1:0];
      wdata_d   = mem_rsp_data_i;
      rsp_cnt_d = rsp_cnt_q + LEN_W'(1);
      if (rsp_bad) err_d = 1'b1;
      if (rsp_last) begin
        state_d = SVL_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  assign ctl_en = start_acc || rsp_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      we_q   <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SVL_IDLE;
      len_q     <= '0;
      vreg_q    <= '0;
      rsp_cnt_q <= '0;
      err_q     <= 1'b0;
    end else if (ctl_en) begin
      state_q   <= state_d;
      len_q     <= len_d;
      vreg_q    <= vreg_d;
      rsp_cnt_q <= rsp_cnt_d;
      err_q     <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      wdata_q <= '0;
    end else if (we_d) begin
      idx_q   <= idx_d;
      wdata_q <= wdata_d;
    end
  end

  assign busy_o          = running;
  assign done_o          = done_q;
  assign ecc_err_o       = err_q;
  assign mem_req_valid_o = issue;
  assign mem_req_addr_o  = cur_addr;
  assign mem_req_bank_o  = cur_addr[BANK_W-1:0];
  assign vrf_we_o        = we_q;
  assign vrf_reg_o       = vreg_q;
  assign vrf_idx_o       = idx_q;
  assign vrf_data_o      = wdata_q;

  // R6: an empty load completes in one cycle and never becomes busy
  p_empty_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid_i && !busy_o && start_len_i == '0) |=> (done_o && !busy_o && !vrf_we_o));

  // R7: the final response yields a write, the done pulse and a return to idle together
  p_done_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mem_rsp_valid_i && rsp_cnt_q == len_q - LEN_W'(1)) |=> (done_o && vrf_we_o && !busy_o));

  // R5: written indices stay below the clamped element count
  p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vrf_we_o |-> ({1'b0, vrf_idx_o} < len_q));

  // R8: a start during a load leaves the destination register untouched
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_valid_i) |=> $stable(vrf_reg_o));

  // R9: the fault flag only clears on an accepted start
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_err_o && !(start_valid_i && !busy_o)) |=> ecc_err_o);

endmodule

// File: tb/test_svl_load_unit.sv
`timescale 1ns/1ps
module test_svl_load_unit;

  localparam int AW = 32;
  localparam int DW = 64;
  localparam int LW = 7;
  localparam int IW = 6;
  localparam int VW = 4;
  localparam int BW = 4;
  localparam int CW = 8;
  localparam int GAP = 4;
  localparam int MAXV = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          start_valid_i = 1'b0;
  logic [AW-1:0] start_base_i = '0;
  logic [AW-1:0] start_stride_i = '0;
  logic [LW-1:0] start_len_i = '0;
  logic [VW-1:0] start_vreg_i = '0;
  logic          busy_o, done_o, ecc_err_o;
  logic          mem_req_valid_o;
  logic [AW-1:0] mem_req_addr_o;
  logic [BW-1:0] mem_req_bank_o;
  logic          mem_rsp_valid_i = 1'b0;
  logic [DW-1:0] mem_rsp_data_i = '0;
  logic [CW-1:0] mem_rsp_check_i = '0;
  logic          vrf_we_o;
  logic [VW-1:0] vrf_reg_o;
  logic [IW-1:0] vrf_idx_o;
  logic [DW-1:0] vrf_data_o;

  svl_load_unit i_svl_load_unit (
    .clk(clk), .rst_n(rst_n),
    .start_valid_i(start_valid_i), .start_base_i(start_base_i),
    .start_stride_i(start_stride_i), .start_len_i(start_len_i),
    .start_vreg_i(start_vreg_i),
    .busy_o(busy_o), .done_o(done_o), .ecc_err_o(ecc_err_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_bank_o(mem_req_bank_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
    .mem_rsp_check_i(mem_rsp_check_i),
    .vrf_we_o(vrf_we_o), .vrf_reg_o(vrf_reg_o), .vrf_idx_o(vrf_idx_o),
    .vrf_data_o(vrf_data_o)
  );

  int n_checks = 0;
  int n_errs = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // check byte per R9
  function automatic int code_of(input int idx);
    int n;
    n = 0;
    for (int c = 3; c < 128; c++) begin
      if ((c & (c - 1)) != 0) begin
        if (n == idx) return c;
        n++;
      end
    end
    return 0;
  endfunction

  function automatic logic [7:0] encode(input logic [63:0] d);
    logic [7:0] c;
    c = '0;
    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < 7; j++) begin
        if (((code_of(i) >> j) & 1) != 0) c[j] = c[j] ^ d[i];
      end
    end
    c[7] = ^{d, c[6:0]};
    return c;
  endfunction

  function automatic logic [63:0] word_of(input logic [31:0] a);
    return {a * 32'h9E3779B9, a ^ 32'h5A5AC3C3};
  endfunction

  logic [31:0] bad_addr = 32'hFFFF_FFFF;
  int          bad_kind = 0;

  function automatic logic [63:0] stored_of(input logic [31:0] a);
    logic [63:0] w;
    w = word_of(a);
    if (a == bad_addr && bad_kind == 1) w[5] = ~w[5];
    if (a == bad_addr && bad_kind == 2) begin
      w[5]  = ~w[5];
      w[40] = ~w[40];
    end
    return w;
  endfunction

  // monitor and memory model state
  int          obs = 0;
  bit          prev_busy = 1'b0;
  bit          m_active = 1'b0;
  bit          m_complete = 1'b0;
  bit          m_err_exp = 1'b0;
  logic [31:0] m_base, m_stride;
  logic [VW-1:0] m_vreg;
  int          m_len = 0, m_iss = 0, m_wr = 0, m_start_obs = 0, m_prev_iss = 0;
  int          last_use [16];
  int          req_obs [64];
  bit          ring_v [4];
  logic [31:0] ring_a [4];

  initial begin
    for (int b = 0; b < 16; b++) last_use[b] = -100;
    for (int k = 0; k < 4; k++) ring_v[k] = 1'b0;
    forever begin
      @(negedge clk);
      obs++;
      if (!rst_n) begin
        prev_busy = 1'b0;
        mem_rsp_valid_i = 1'b0;
      end else begin
        // drive a due response
        mem_rsp_valid_i = ring_v[obs % 4];
        if (ring_v[obs % 4]) begin
          mem_rsp_data_i  = stored_of(ring_a[obs % 4]);
          mem_rsp_check_i = encode(word_of(ring_a[obs % 4]));
        end
        ring_v[obs % 4] = 1'b0;

        // start capture (R8: only when idle)
        if (start_valid_i && !prev_busy) begin
          m_base      = start_base_i;
          m_stride    = start_stride_i;
          m_vreg      = start_vreg_i;
          m_len       = (int'(start_len_i) > MAXV) ? MAXV : int'(start_len_i);
          m_iss       = 0;
          m_wr        = 0;
          m_start_obs = obs;
          m_err_exp   = 1'b0;
          m_complete  = 1'b0;
          if (m_len == 0) begin
            check(done_o === 1'b1, "R6", "done after empty start", 64'(done_o), 64'd1);
            check(busy_o === 1'b0, "R6", "busy after empty start", 64'(busy_o), 64'd0);
            m_active   = 1'b0;
            m_complete = 1'b1;
          end else begin
            check(busy_o === 1'b1, "R7", "busy after start", 64'(busy_o), 64'd1);
            m_active = 1'b1;
          end
        end

        // request check (R2, R3)
        if (mem_req_valid_o === 1'b1) begin
          if (!m_active || m_iss >= m_len) begin
            check(1'b0, "R2", "unexpected request", 64'(mem_req_addr_o), 64'd0);
          end else begin
            logic [31:0] ea;
            int          eb, earliest, eobs;
            ea = m_base + m_stride * 32'(m_iss);
            eb = int'(ea[3:0]);
            earliest = (m_iss == 0) ? m_start_obs : m_prev_iss + 1;
            eobs = (last_use[eb] + GAP > earliest) ? last_use[eb] + GAP : earliest;
            check(mem_req_addr_o === ea, "R2", "element address", 64'(mem_req_addr_o), 64'(ea));
            check(int'(mem_req_bank_o) == eb, "R2", "bank", 64'(mem_req_bank_o), 64'(eb));
            check(obs == eobs, "R3", "issue cycle", 64'(obs - m_start_obs), 64'(eobs - m_start_obs));
            last_use[int'(mem_req_addr_o[3:0])] = obs;
            req_obs[m_iss] = obs;
            m_prev_iss = obs;
            if (ea == bad_addr && bad_kind == 2) m_err_exp = 1'b1;
            ring_v[(obs + 2) % 4] = 1'b1;
            ring_a[(obs + 2) % 4] = mem_req_addr_o;
            m_iss++;
          end
        end

        // write check (R4, R7)
        if (vrf_we_o === 1'b1) begin
          if (!m_active || m_wr >= m_iss) begin
            check(1'b0, "R4", "unexpected write", 64'(vrf_idx_o), 64'd0);
          end else begin
            logic [31:0] wa;
            wa = m_base + m_stride * 32'(m_wr);
            check(int'(vrf_idx_o) == m_wr, "R4", "write index", 64'(vrf_idx_o), 64'(m_wr));
            check(vrf_reg_o === m_vreg, "R4", "write register", 64'(vrf_reg_o), 64'(m_vreg));
            check(vrf_data_o === stored_of(wa), "R4", "write data", vrf_data_o, stored_of(wa));
            check(obs == req_obs[m_wr] + 3, "R4", "write cycle", 64'(obs - req_obs[m_wr]), 64'd3);
            m_wr++;
            if (m_wr == m_len) begin
              check(done_o === 1'b1, "R7", "done with last write", 64'(done_o), 64'd1);
              check(busy_o === 1'b0, "R7", "idle at done", 64'(busy_o), 64'd0);
              m_active   = 1'b0;
              m_complete = 1'b1;
            end else begin
              check(done_o === 1'b0, "R7", "early done", 64'(done_o), 64'd0);
            end
          end
        end else if (done_o === 1'b1 && !(m_complete && m_len == 0 && m_start_obs == obs)) begin
          check(1'b0, "R7", "done without final write", 64'(done_o), 64'd0);
        end
        prev_busy = busy_o;
      end
    end
  end

  task automatic run_load(input logic [31:0] base, input logic [31:0] stride,
                          input int len, input logic [VW-1:0] vreg, input bit poke);
    int exp_n;
    int waited;
    exp_n = (len > MAXV) ? MAXV : len;
    @(negedge clk); #1;
    start_valid_i  = 1'b1;
    start_base_i   = base;
    start_stride_i = stride;
    start_len_i    = LW'(len);
    start_vreg_i   = vreg;
    @(negedge clk); #1;
    start_valid_i = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      #1;
      start_valid_i  = 1'b1;  // R8: ignored while busy
      start_base_i   = base + 32'd5;
      start_stride_i = stride + 32'd1;
      start_len_i    = 7'd3;
      start_vreg_i   = vreg ^ 4'hF;
      @(negedge clk); #1;
      start_valid_i = 1'b0;
    end
    waited = 0;
    while (!m_complete && waited < 3000) begin
      @(negedge clk); #1;
      waited++;
    end
    check(m_complete, "R7", "load completion", 64'(m_wr), 64'(exp_n));
    check(m_iss == exp_n, "R2", "request count", 64'(m_iss), 64'(exp_n));
    check(m_wr == exp_n, "R4", "write count", 64'(m_wr), 64'(exp_n));
    check(ecc_err_o === m_err_exp, "R9", "fault flag", 64'(ecc_err_o), 64'(m_err_exp));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy_o === 1'b0, "R1", "busy in reset", 64'(busy_o), 64'd0);
    check(done_o === 1'b0, "R1", "done in reset", 64'(done_o), 64'd0);
    check(ecc_err_o === 1'b0, "R1", "flag in reset", 64'(ecc_err_o), 64'd0);
    check(mem_req_valid_o === 1'b0, "R1", "request in reset", 64'(mem_req_valid_o), 64'd0);
    check(vrf_we_o === 1'b0, "R1", "write in reset", 64'(vrf_we_o), 64'd0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(busy_o === 1'b0 && mem_req_valid_o === 1'b0, "R1", "idle after reset",
          64'(busy_o), 64'd0);

    // R2, R3: stride sweep over all bank-mapping patterns
    for (int s = 0; s < 34; s++) run_load(32'(s * 7), 32'(s), 24, VW'(s), 1'b0);
    // R2: wrap-around and negative strides
    run_load(32'hFFFF_FFF0, 32'd3, 20, 4'd2, 1'b0);
    run_load(32'd40, 32'hFFFF_FFFF, 30, 4'd3, 1'b0);
    run_load(32'd1000, 32'hFFFF_FFF0, 12, 4'd4, 1'b0);
    run_load(32'd9, 32'h8000_0008, 16, 4'd5, 1'b0);

    // R5, R6: length sweep including empty and above-limit counts
    for (int l = 0; l < 67; l++) run_load(32'd100, 32'd5, l, 4'd6, 1'b0);
    run_load(32'd7, 32'd1, 100, 4'd7, 1'b0);
    check(m_wr == 64, "R5", "clamped count len=100", 64'(m_wr), 64'd64);
    run_load(32'd7, 32'd2, 127, 4'd8, 1'b0);
    check(m_wr == 64, "R5", "clamped count len=127", 64'(m_wr), 64'd64);

    // R8: start presented while busy
    run_load(32'd300, 32'd16, 40, 4'd9, 1'b1);

    // R9: single fault not flagged, double fault flagged, next start clears
    bad_kind = 1; bad_addr = 32'd500 + 32'd5 * 32'd3;
    run_load(32'd500, 32'd3, 10, 4'd10, 1'b0);
    bad_kind = 2; bad_addr = 32'd500 + 32'd7 * 32'd3;
    run_load(32'd500, 32'd3, 10, 4'd11, 1'b0);
    check(ecc_err_o === 1'b1, "R9", "flag held after done", 64'(ecc_err_o), 64'd1);
    bad_kind = 0; bad_addr = 32'hFFFF_FFFF;
    run_load(32'd500, 32'd3, 10, 4'd12, 1'b0);
    check(ecc_err_o === 1'b0, "R9", "flag cleared by start", 64'(ecc_err_o), 64'd0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule